// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is an 8-bit synchronous serial shifter that software reaches through a small register bus. The serial interface has three lines: a shift clock, a serial data output and a serial data input. Software loads a byte into the shift register, picks a clock ratio and a clock phase, and sets a busy bit to start a transfer. While the transfer runs, the byte goes out most significant bit first, and the incoming bits are assembled into the same register. When the eighth bit completes, the busy bit clears by itself and a sticky pending flag is raised.

In master mode the block makes the shift clock itself by dividing the system clock, which serves as the instruction-cycle clock. In slave mode the divider is not used, and each bit follows the edges of a shift clock that comes in on the clock pad. The shift-clock and data-out lines share two pads with general-purpose port bits. A routing bit decides whether the shifter or the port logic drives those pads.

Register map, selected by `bus_addr`:
- 0: shift data.
- 1: control. Bits [1:0] are the divide code, bit 2 routes the pads, bit 3 selects the alternate phase and bit 4 selects slave mode.
- 2: status. Bit 0 is busy and bit 1 is pending.

Reads of address 3 return zero.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, the data, control and status registers all read 0.
- R2: In master mode, a transfer keeps busy high for 16 × H system clocks. H is 1 for divide code 00, 2 for code 01, and 4 for codes 10 and 11. The shift clock therefore runs at the system clock divided by 2, 4 or 8.
- R3: The data line (pad bit 0) sends the loaded byte most significant bit first. When the transfer ends, the data register holds the eight received bits, with the first one received in bit 7.
- R4: In normal phase (control bit 3 = 0) the shift clock idles low. The input is sampled on its rising edge, and the output changes only on its falling edge. In alternate phase the clock idles high and the two edges swap roles. The output never changes on the sampling edge.
- R5: Writing 1 to status bit 0 while idle starts a transfer. Busy clears by itself after the eighth bit, and pending is set in the same cycle.
- R6: Pending stays set until a status write with bit 1 = 1. A status write with bit 1 = 0 leaves it set.
- R7: When control bit 2 = 0, `pad_out` and `pad_oe` equal `gp_out` and `gp_oe`. When it is 1, pad bit 0 carries the data output with its enable on, and pad bit 1 carries the shift clock.
- R8: In slave mode (control bit 4 = 1), pad bit 1 is not driven (its enable is 0 when routed). Each bit is sampled and shifted on the edges of `sk_pad_in`, using the same phase rules as R4.
- R9: While busy is high, writes to the data and control registers and start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (instruction-cycle clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| gp_out | input | 2 | Port-logic output values for the shared pads |
| gp_oe | input | 2 | Port-logic output enables for the shared pads |
| sk_pad_in | input | 1 | Shift clock from the pad (slave mode) |
| si_pad_in | input | 1 | Serial data input |
| pad_out | output | 2 | Shared pad values: bit 0 data out, bit 1 shift clock |
| pad_oe | output | 2 | Shared pad output enables |

## Verification
The bench builds the block with its default 8-bit width. It sweeps all four divide codes under both clock phases, with several data patterns for each.

A bench-side peer watches the shift-clock pad, feeds a known input pattern and records the output bits. This allows the bit order, the edge roles and the exact busy length to be checked for every combination.

Slave mode is driven with a bench-generated clock in both phases. Pad routing is swept over all port-logic value and enable combinations.

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    gp_out,
  input  logic [1:0]    gp_oe,
  input  logic          sk_pad_in,
  input  logic          si_pad_in,
  output logic [1:0]    pad_out,
  output logic [1:0]    pad_oe
);
  localparam int NW = $clog2(DW + 1);

  logic [DW-1:0] sr;
  logic [1:0]    div;
  logic          route, alt, slave;
  logic          busy, pend, ph, rxb;
  logic [1:0]    hcnt;
  logic [NW-1:0] nbits;
  logic [2:0]    sks;

  logic [1:0] half_m1;
  assign half_m1 = (div == 2'd0) ? 2'd0 : (div == 2'd1) ? 2'd1 : 2'd3;

  logic tick_m, ext_edge, ext_act, do_sample, do_shift, wr_idle, sk_int;
  assign tick_m    = busy & ~slave & (hcnt == half_m1);
  assign ext_edge  = sks[2] ^ sks[1];
  assign ext_act   = sks[1] ^ alt;
  assign do_sample = busy & ~ph & (slave ? (ext_edge & ext_act) : tick_m);
  assign do_shift  = busy & ph & (slave ? (ext_edge & ~ext_act) : tick_m);
  assign wr_idle   = bus_wr & ~busy;
  assign sk_int    = (busy & ~slave & ph) ^ alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      div   <= '0;
      route <= 1'b0;
      alt   <= 1'b0;
      slave <= 1'b0;
      busy  <= 1'b0;
      pend  <= 1'b0;
      ph    <= 1'b0;
      rxb   <= 1'b0;
      hcnt  <= '0;
      nbits <= '0;
      sks   <= '0;
    end else begin
      sks <= {sks[1:0], sk_pad_in};
      if (busy && !slave) hcnt <= tick_m ? 2'd0 : hcnt + 2'd1;
      if (bus_wr && bus_addr == 2'd2 && bus_wdata[1]) pend <= 1'b0;
      if (wr_idle) begin
        case (bus_addr)
          2'd0: sr <= bus_wdata;
          2'd1: begin
            div   <= bus_wdata[1:0];
            route <= bus_wdata[2];
            alt   <= bus_wdata[3];
            slave <= bus_wdata[4];
          end
          2'd2: if (bus_wdata[0]) begin
            busy  <= 1'b1;
            hcnt  <= '0;
            ph    <= 1'b0;
            nbits <= '0;
          end
          default: ;
        endcase
      end
      if (do_sample) begin
        ph  <= 1'b1;
        rxb <= si_pad_in;
      end
      if (do_shift) begin
        ph    <= 1'b0;
        sr    <= {sr[DW-2:0], rxb};
        nbits <= nbits + 1'b1;
        if (nbits == NW'(DW - 1)) begin
          busy  <= 1'b0;
          pend  <= 1'b1;
          nbits <= '0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = sr;
      2'd1: bus_rdata[4:0] = {slave, alt, route, div};
      2'd2: bus_rdata[1:0] = {pend, busy};
      default: ;
    endcase
  end

  assign pad_out[0] = route ? sr[DW-1] : gp_out[0];
  assign pad_oe[0]  = route ? 1'b1     : gp_oe[0];
  assign pad_out[1] = route ? sk_int   : gp_out[1];
  assign pad_oe[1]  = route ? ~slave   : gp_oe[1];
endmodule

module serial_shift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       pend,
  input logic       route,
  input logic       alt,
  input logic       slave,
  input logic [1:0] div,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       clr_bit,
  input logic [1:0] gp_out,
  input logic [1:0] gp_oe,
  input logic [1:0] pad_out,
  input logic [1:0] pad_oe
);
  p_busy_end_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pend);
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(bus_wr && bus_addr == 2'd2 && clr_bit)) |=> pend);
  p_route_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !route |-> (pad_out == gp_out && pad_oe == gp_oe));
  p_slave_sk_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route && slave) |-> !pad_oe[1]);
  p_sk_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route && !busy) |-> (pad_out[1] == alt));
  p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({div, route, alt, slave}));
endmodule

bind serial_shift_port serial_shift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pend(pend), .route(route),
  .alt(alt), .slave(slave), .div(div), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .clr_bit(bus_wdata[1]), .gp_out(gp_out), .gp_oe(gp_oe),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_serial_shift_port.sv
module tb_serial_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] gp_out = '0, gp_oe = '0;
  logic       sk_pad_in = 1'b0, si_pad_in = 1'b0;
  logic [1:0] pad_out, pad_oe;

  int checks = 0, errors = 0;

  serial_shift_port dut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  logic       mon_on = 1'b0, mon_alt = 1'b0, prev_sk, prev_so;
  logic [7:0] si_pat, so_cap;
  int         si_idx, phase_err;

  always @(negedge clk) begin
    if (mon_on) begin
      if (pad_out[1] != prev_sk) begin
        if (pad_out[1] != mon_alt) begin
          if (pad_out[0] != prev_so) phase_err++;
          so_cap = {so_cap[6:0], pad_out[0]};
        end else begin
          si_idx--;
          if (si_idx >= 0) si_pad_in = si_pat[si_idx];
        end
      end
      prev_sk = pad_out[1];
      prev_so = pad_out[0];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats[4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); check(d == 8'h00, "R1 data reset", d, 0);
    rd(2'd1, d); check(d == 8'h00, "R1 control reset", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R1 status reset", d, 0);

    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      gp_out = v[1:0]; gp_oe = v[3:2];
      #1 check(pad_out == v[1:0] && pad_oe == v[3:2], "R7 pads follow port logic",
               {pad_oe, pad_out}, v);
    end

    for (int dc = 0; dc < 4; dc++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int p = 0; p < 4; p++) begin
          int half, cnt;
          logic [7:0] tx, rxp;
          half = (dc == 0) ? 1 : (dc == 1) ? 2 : 4;
          tx = pats[p] ^ 8'(dc * 16 + ph);
          rxp = ~pats[(p + 1) % 4];
          wr(2'd1, 8'(dc | 4 | (ph << 3)));
          wr(2'd0, tx);
          wr(2'd2, 8'h02);
          @(negedge clk);
          check(pad_out[1] == ph[0], "R4 idle clock level", pad_out[1], ph);
          check(pad_out[0] == tx[7] && pad_oe == 2'b11, "R7 routed pads",
                {pad_oe, pad_out[0]}, {2'b11, tx[7]});
          si_pat = rxp; si_idx = 7; si_pad_in = rxp[7];
          mon_alt = ph[0]; prev_sk = ph[0]; prev_so = tx[7]; so_cap = '0; phase_err = 0;
          mon_on = 1'b1;
          wr(2'd2, 8'h01);
          bus_addr = 2'd2;
          cnt = 1;
          wr(2'd0, 8'h55);
          wr(2'd1, 8'h00);
          wr(2'd2, 8'h01);
          cnt += 6;
          bus_addr = 2'd2;
          forever begin
            @(negedge clk);
            #1;
            if (!bus_rdata[0]) break;
            cnt++;
          end
          mon_on = 1'b0;
          check(cnt == 16 * half, "R2 busy length", cnt, 16 * half);
          check(bus_rdata[1] == 1'b1, "R5 pending after transfer", bus_rdata, 2);
          check(so_cap == tx, "R3 MSB-first output", so_cap, tx);
          check(phase_err == 0, "R4 output stable on sample edge", phase_err, 0);
          rd(2'd0, d); check(d == rxp, "R3 received byte / R9 data write ignored", d, rxp);
          rd(2'd1, d); check(d == 8'(dc | 4 | (ph << 3)), "R9 control write ignored",
                             d, dc | 4 | (ph << 3));
          wr(2'd2, 8'h00);
          rd(2'd2, d); check(d == 8'h02, "R6 pending kept", d, 2);
          wr(2'd2, 8'h02);
          rd(2'd2, d); check(d == 8'h00, "R6 pending cleared", d, 0);
        end
      end
    end

    for (int ph = 0; ph < 2; ph++) begin
      logic [7:0] tx, rxp, cap;
      int eb;
      tx = 8'hC3 ^ 8'(ph * 8'h5A);
      rxp = 8'h96 ^ 8'(ph);
      sk_pad_in = ph[0];
      wr(2'd1, 8'(4 | 16 | (ph << 3)));
      wr(2'd0, tx);
      repeat (4) @(negedge clk);
      check(pad_oe == 2'b01, "R8 clock pad not driven", pad_oe, 1);
      wr(2'd2, 8'h01);
      cap = '0; eb = 0;
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk);
        si_pad_in = rxp[b];
        if (pad_out[0] != tx[b]) eb++;
        cap = {cap[6:0], pad_out[0]};
        sk_pad_in = ~ph[0];
        repeat (4) @(negedge clk);
        sk_pad_in = ph[0];
        repeat (4) @(negedge clk);
      end
      check(cap == tx && eb == 0, "R8 slave output MSB first", cap, tx);
      rd(2'd0, d); check(d == rxp, "R8 slave received byte", d, rxp);
      rd(2'd2, d); check(d == 8'h02, "R8 slave done, pending", d, 2);
      wr(2'd2, 8'h02);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule